// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block checks each processor access against eight programmable address windows and one background permission set. The address space is cut into 16-byte pages, and the page number of an access is its address with the low four bits dropped. Each window covers a range of pages that includes both its first and its last page. Each window also carries a valid flag and three grant bits: read, write and execute. An instruction fetch needs execute, an operand read needs read, and an operand write needs write. When windows overlap, their grant bits are combined by OR. The background set is also ORed in, so a single granting source is enough to allow the access.

Checking applies only while the processor reports user mode and the global enable is set. In supervisor mode, or while the unit is disabled, every access is allowed. The allow and fault outputs are combinational from the access request. A fault does not start any exception sequence here; the processor receives only the fault signal.

On the first fault the block records a sticky reason bit. For an operand access it also records the full faulting address. Later faults change nothing until software clears the reason bits by writing ones to them. A small word-addressed register port sets up the windows, the background set and the enable, and reads back all state. Read data is registered.

Top module: `mpu_guard`

## Requirements
- R1: After a synchronous reset, the enable, the background set, every window register, the reason bits and the error address all read 0. While the unit is disabled after reset, user accesses are allowed.
- R2: When `acc_user` is 0 (supervisor mode), every valid access gives `acc_allow`=1 and `acc_fault`=0, whatever the configuration.
- R3: The enable is bit 0 of the control word at word address 0. While it is 0, user accesses are allowed.
- R4: Window n matches when start_page <= acc_addr[31:4] <= end_page, compared unsigned. Both boundary pages match. The page just below the start and the page just above the end do not match.
- R5: A window whose valid flag is 0 never matches. A window whose start page is greater than its end page matches nothing.
- R6: The `acc_kind` encoding selects the grant bit. 0 is a fetch and needs execute (grant bit 2). 1 is a read and needs read (grant bit 0). 2 and 3 are writes and need write (grant bit 1).
- R7: When an access falls in several valid windows, the effective grant is the OR of their grant bits.
- R8: The background grant word (word address 1, bits [2:0]: bit 0 read, bit 1 write, bit 2 execute) applies to every address and is ORed with any matching windows.
- R9: A checked access that receives no grant gives `acc_fault`=1 and `acc_allow`=0, in the same cycle. With `acc_valid`=1 exactly one of the two outputs is high. With `acc_valid`=0 both are low.
- R10: The reason word is at word address 3: bit 0 is a read violation, bit 1 a write violation, bit 2 an execute violation. The error address is at word address 2. When all reason bits are 0, a fault sets the bit for its kind on the next clock edge. An operand fault also loads the error address with the full `acc_addr`. A fetch fault leaves the error address unchanged.
- R11: While any reason bit is set, later faults change neither the reason word nor the error address. Writing 1s to the reason word clears the matching bits.
- R12: Window n uses word addresses 16+2n and 17+2n. The start word holds the start page in bits [31:4] and the grant bits in [2:0]. The end word holds the end page in bits [31:4] and the valid flag in bit 0. A read strobe returns the addressed word on `cfg_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 or 3 write |
| acc_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| acc_allow | output | 1 | Access permitted (combinational) |
| acc_fault | output | 1 | Protection fault (combinational) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |

## Verification
The in-RTL assertions check the following on every cycle:
- supervisor mode and the disabled state never produce a fault;
- the allow and fault outputs are mutually exclusive and both low when no access is presented;
- the reason word holds at most one set bit;
- a locked reason word and error address stay unchanged;
- the first operand fault loads the error address;
- a first fetch fault leaves the error address alone.

Only the bench scenarios can show:
- the decisions at window page boundaries;
- the OR-combining of overlapping windows and the background;
- the handling of invalid and inverted windows;
- the register layout seen through readback.

The bench predicts each of these from its own copy of the written configuration.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

  // Grant bits: bit 0 read, bit 1 write, bit 2 execute
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam int unsigned CFG_CTRL     = 0;
  localparam int unsigned CFG_BG       = 1;
  localparam int unsigned CFG_EADDR    = 2;
  localparam int unsigned CFG_ESTAT    = 3;
  localparam int unsigned CFG_RGN_BASE = 16;

  // Access kind: 0 fetch, 1 read, 2/3 write
  function automatic logic perm_pick(perm_t p, logic [1:0] kind);
    if (kind[1])      return p.w;
    else if (kind[0]) return p.r;
    else              return p.x;
  endfunction

endpackage

// File: rtl/mpg_region_cmp.sv
module mpg_region_cmp
  import mpg_pkg::*;
#(
  parameter int unsigned PAGE_W = 28
) (
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic              valid,
  input  perm_t             perm,
  input  logic [PAGE_W-1:0] page,
  output perm_t             grant
);

  logic above_start;
  logic below_end;
  logic hit;

  always_comb begin
    above_start = (page >= start_pg);
    below_end   = (page <= end_pg);
    hit         = valid && above_start && below_end;
    grant       = hit ? perm : perm_t'('0);
  end

endmodule

// File: rtl/mpg_cfg_regs.sv
module mpg_cfg_regs
  import mpg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 4,
  parameter int unsigned NUM_RGN    = 8,
  parameter int unsigned CFG_AW     = 6,
  localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic                           cfg_rd,
  input  logic [CFG_AW-1:0]              cfg_addr,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [ADDR_W-1:0]              cfg_rdata,
  output logic                           en,
  output perm_t                          bg_perm,
  output logic [NUM_RGN-1:0][PAGE_W-1:0] rg_start,
  output logic [NUM_RGN-1:0][PAGE_W-1:0] rg_end,
  output logic [NUM_RGN-1:0]             rg_valid,
  output perm_t [NUM_RGN-1:0]            rg_perm,
  input  logic                           flt_evt,
  input  logic [1:0]                     flt_kind,
  input  logic [ADDR_W-1:0]              flt_addr
);

  logic                           en_q;
  perm_t                          bg_q;
  logic [NUM_RGN-1:0][PAGE_W-1:0] start_q;
  logic [NUM_RGN-1:0][PAGE_W-1:0] end_q;
  logic [NUM_RGN-1:0]             valid_q;
  perm_t [NUM_RGN-1:0]            perm_q;
  logic [2:0]                     estat_q;
  logic [ADDR_W-1:0]              eaddr_q;

  logic [2:0]        stat_nxt;
  logic [ADDR_W-1:0] eaddr_nxt;
  logic              clr_hit;
  logic [ADDR_W-1:0] rd_mux;
  logic              unused_bits;

  assign unused_bits = ^cfg_wdata[PAGE_SHIFT-1:3];

  // Sticky first-fault capture with write-one-to-clear
  always_comb begin
    clr_hit   = cfg_wr && (cfg_addr == CFG_AW'(CFG_ESTAT));
    stat_nxt  = estat_q & ~(clr_hit ? cfg_wdata[2:0] : 3'b000);
    eaddr_nxt = eaddr_q;
    if (flt_evt && (estat_q == 3'b000)) begin
      if (flt_kind[1]) begin
        stat_nxt  = 3'b010;
        eaddr_nxt = flt_addr;
      end else if (flt_kind[0]) begin
        stat_nxt  = 3'b001;
        eaddr_nxt = flt_addr;
      end else begin
        stat_nxt  = 3'b100;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      bg_q    <= '0;
      start_q <= '0;
      end_q   <= '0;
      valid_q <= '0;
      perm_q  <= '0;
      estat_q <= '0;
      eaddr_q <= '0;
    end else begin
      if (cfg_wr && (cfg_addr == CFG_AW'(CFG_CTRL))) en_q <= cfg_wdata[0];
      if (cfg_wr && (cfg_addr == CFG_AW'(CFG_BG)))   bg_q <= perm_t'(cfg_wdata[2:0]);
      for (int n = 0; n < NUM_RGN; n++) begin
        if (cfg_wr && (cfg_addr == CFG_AW'(CFG_RGN_BASE + 2 * n))) begin
          start_q[n] <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
          perm_q[n]  <= perm_t'(cfg_wdata[2:0]);
        end
        if (cfg_wr && (cfg_addr == CFG_AW'(CFG_RGN_BASE + 2 * n + 1))) begin
          end_q[n]   <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
          valid_q[n] <= cfg_wdata[0];
        end
      end
      estat_q <= stat_nxt;
      eaddr_q <= eaddr_nxt;
    end
  end

  // Readback mux
  always_comb begin
    rd_mux = '0;
    if (cfg_addr == CFG_AW'(CFG_CTRL))  rd_mux[0]   = en_q;
    if (cfg_addr == CFG_AW'(CFG_BG))    rd_mux[2:0] = bg_q;
    if (cfg_addr == CFG_AW'(CFG_EADDR)) rd_mux      = eaddr_q;
    if (cfg_addr == CFG_AW'(CFG_ESTAT)) rd_mux[2:0] = estat_q;
    for (int n = 0; n < NUM_RGN; n++) begin
      if (cfg_addr == CFG_AW'(CFG_RGN_BASE + 2 * n)) begin
        rd_mux[ADDR_W-1:PAGE_SHIFT] = start_q[n];
        rd_mux[2:0]                 = perm_q[n];
      end
      if (cfg_addr == CFG_AW'(CFG_RGN_BASE + 2 * n + 1)) begin
        rd_mux[ADDR_W-1:PAGE_SHIFT] = end_q[n];
        rd_mux[0]                   = valid_q[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_mux;
  end

  assign en       = en_q;
  assign bg_perm  = bg_q;
  assign rg_start = start_q;
  assign rg_end   = end_q;
  assign rg_valid = valid_q;
  assign rg_perm  = perm_q;

  AST_STAT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(estat_q)); // R10

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (estat_q != 3'b000 && !clr_hit) |=> ($stable(estat_q) && $stable(eaddr_q))); // R11

  AST_DATA_LATCH: assert property (@(posedge clk) disable iff (rst)
    (estat_q == 3'b000 && flt_evt && flt_kind != 2'b00) |=> (eaddr_q == $past(flt_addr))); // R10

  AST_FETCH_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (estat_q == 3'b000 && flt_evt && flt_kind == 2'b00) |=> ($stable(eaddr_q) && estat_q[2])); // R10

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 4,
  parameter int unsigned NUM_RGN    = 8,
  parameter int unsigned CFG_AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              acc_user,
  output logic              acc_allow,
  output logic              acc_fault,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata
);

  localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;

  logic                           en;
  perm_t                          bg_perm;
  logic [NUM_RGN-1:0][PAGE_W-1:0] rg_start;
  logic [NUM_RGN-1:0][PAGE_W-1:0] rg_end;
  logic [NUM_RGN-1:0]             rg_valid;
  perm_t [NUM_RGN-1:0]            rg_perm;
  perm_t [NUM_RGN-1:0]            rg_grant;
  perm_t                          eff_perm;
  logic [PAGE_W-1:0]              page;
  logic                           granted;
  logic                           checking;

  assign page = acc_addr[ADDR_W-1:PAGE_SHIFT];

  mpg_cfg_regs #(
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .NUM_RGN   (NUM_RGN),
    .CFG_AW    (CFG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .en       (en),
    .bg_perm  (bg_perm),
    .rg_start (rg_start),
    .rg_end   (rg_end),
    .rg_valid (rg_valid),
    .rg_perm  (rg_perm),
    .flt_evt  (acc_fault),
    .flt_kind (acc_kind),
    .flt_addr (acc_addr)
  );

  for (genvar n = 0; n < NUM_RGN; n++) begin : g_rgn
    mpg_region_cmp #(.PAGE_W(PAGE_W)) u_cmp (
      .start_pg(rg_start[n]),
      .end_pg  (rg_end[n]),
      .valid   (rg_valid[n]),
      .perm    (rg_perm[n]),
      .page    (page),
      .grant   (rg_grant[n])
    );
  end

  // Any granting source wins
  always_comb begin
    eff_perm = bg_perm;
    for (int n = 0; n < NUM_RGN; n++) eff_perm = eff_perm | rg_grant[n];
    granted   = perm_pick(eff_perm, acc_kind);
    checking  = acc_user && en;
    acc_fault = acc_valid && checking && !granted;
    acc_allow = acc_valid && !acc_fault;
  end

  AST_SUPV_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_user) |-> acc_allow); // R2

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !en) |-> acc_allow); // R3

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot({acc_allow, acc_fault})); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> (!acc_allow && !acc_fault)); // R9

endmodule

// File: tb/mpu_guard_bench.sv
module mpu_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_user = 1'b0;
  logic        acc_allow, acc_fault;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  logic [27:0] sh_start [NR];
  logic [27:0] sh_end   [NR];
  logic [2:0]  sh_perm  [NR];
  logic        sh_val   [NR];
  logic [2:0]  sh_bg;
  logic        sh_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_guard u_mpu_guard (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .acc_user(acc_user), .acc_allow(acc_allow),
    .acc_fault(acc_fault), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected {allow, fault}
  function automatic logic [1:0] model(input logic [31:0] a, input logic [1:0] k,
                                       input logic u);
    logic [2:0] eff;
    logic g;
    if (!u || !sh_en) return 2'b10;
    eff = sh_bg;
    for (int n = 0; n < NR; n++)
      if (sh_val[n] && a[31:4] >= sh_start[n] && a[31:4] <= sh_end[n]) eff = eff | sh_perm[n];
    g = k[1] ? eff[1] : (k[0] ? eff[0] : eff[2]);
    return g ? 2'b10 : 2'b01;
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] k, input logic u,
                        input string req);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_user = u;
    exp_q.push_back(model(a, k, u));
    tag_q.push_back(req);
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  // Monitor: pops expected results while an access is presented
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected access result", {30'd0, acc_allow, acc_fault}, 32'd0);
        end else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({acc_allow, acc_fault} == e, t, $sformatf("allow/fault @%h", acc_addr),
                {30'd0, acc_allow, acc_fault}, {30'd0, e});
        end
      end else begin
        check(!acc_allow && !acc_fault, "R9", "idle outputs",
              {30'd0, acc_allow, acc_fault}, 32'd0);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
    check(cfg_rdata == exp, req, $sformatf("readback word %0d", a), cfg_rdata, exp);
  endtask

  task automatic set_rgn(input int n, input logic [31:0] sa, input logic [31:0] ea,
                         input logic [2:0] p, input logic v);
    sh_start[n] = sa[31:4]; sh_end[n] = ea[31:4]; sh_perm[n] = p; sh_val[n] = v;
    wr(6'(16 + 2 * n), {sa[31:4], 1'b0, p});
    wr(6'(17 + 2 * n), {ea[31:4], 3'b000, v});
  endtask

  task automatic set_bg(input logic [2:0] p);
    sh_bg = p;
    wr(6'd1, {29'd0, p});
  endtask

  task automatic set_en(input logic e);
    sh_en = e;
    wr(6'd0, {31'd0, e});
  endtask

  initial begin
    for (int n = 0; n < NR; n++) begin
      sh_start[n] = '0; sh_end[n] = '0; sh_perm[n] = '0; sh_val[n] = 1'b0;
    end
    sh_bg = '0; sh_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd_chk(6'd0, 32'd0, "R1");
    rd_chk(6'd3, 32'd0, "R1");
    rd_chk(6'd2, 32'd0, "R1");
    rd_chk(6'd17, 32'd0, "R1");
    access(32'h0000_1234, 2'd1, 1'b1, "R1");

    // R9/R10: first fault captured
    set_en(1'b1);
    access(32'h0000_1000, 2'd1, 1'b1, "R9");
    rd_chk(6'd3, 32'd1, "R10");
    rd_chk(6'd2, 32'h0000_1000, "R10");
    // R11: second fault does not overwrite
    access(32'h0000_2004, 2'd2, 1'b1, "R9");
    rd_chk(6'd3, 32'd1, "R11");
    rd_chk(6'd2, 32'h0000_1000, "R11");
    wr(6'd3, 32'd1);
    rd_chk(6'd3, 32'd0, "R11");

    // R2: supervisor bypass
    access(32'h0000_2004, 2'd2, 1'b0, "R2");
    access(32'h0000_3000, 2'd0, 1'b0, "R2");

    // R4: inclusive page boundaries
    set_rgn(0, 32'h0000_1000, 32'h0000_1FF0, 3'b001, 1'b1);
    access(32'h0000_0FFF, 2'd1, 1'b1, "R4");
    rd_chk(6'd2, 32'h0000_0FFF, "R10");
    wr(6'd3, 32'd7);
    access(32'h0000_1000, 2'd1, 1'b1, "R4");
    access(32'h0000_1FFF, 2'd1, 1'b1, "R4");
    access(32'h0000_2000, 2'd1, 1'b1, "R4");
    wr(6'd3, 32'd7);

    // R6: kind selects grant bit
    access(32'h0000_1500, 2'd2, 1'b1, "R6");
    rd_chk(6'd3, 32'd2, "R10");
    rd_chk(6'd2, 32'h0000_1500, "R10");
    wr(6'd3, 32'd7);
    access(32'h0000_1500, 2'd0, 1'b1, "R6");
    rd_chk(6'd3, 32'd4, "R10");
    rd_chk(6'd2, 32'h0000_1500, "R10");
    wr(6'd3, 32'd7);
    access(32'h0000_1500, 2'd3, 1'b1, "R6");
    rd_chk(6'd3, 32'd2, "R6");
    wr(6'd3, 32'd7);

    // R7: overlap ORs grants
    set_rgn(1, 32'h0000_1800, 32'h0000_2FF0, 3'b010, 1'b1);
    access(32'h0000_1800, 2'd2, 1'b1, "R7");
    access(32'h0000_1800, 2'd1, 1'b1, "R7");
    access(32'h0000_17F0, 2'd2, 1'b1, "R7");
    access(32'h0000_2800, 2'd1, 1'b1, "R7");

    // R5: invalid and inverted windows
    set_rgn(2, 32'h0000_0000, 32'hFFFF_FFF0, 3'b100, 1'b0);
    access(32'h0000_1000, 2'd0, 1'b1, "R5");
    set_rgn(3, 32'h0000_5000, 32'h0000_4000, 3'b100, 1'b1);
    access(32'h0000_4800, 2'd0, 1'b1, "R5");
    access(32'h0000_5000, 2'd0, 1'b1, "R5");

    // R8: background
    set_bg(3'b100);
    access(32'h0000_9000, 2'd0, 1'b1, "R8");
    access(32'h0000_9000, 2'd1, 1'b1, "R8");
    access(32'h0000_1000, 2'd0, 1'b1, "R8");
    access(32'h0000_1000, 2'd1, 1'b1, "R8");
    set_bg(3'b101);
    access(32'hFFFF_FFFC, 2'd1, 1'b1, "R8");

    // R12: layout readback
    rd_chk(6'd16, 32'h0000_1001, "R12");
    rd_chk(6'd17, 32'h0000_1FF1, "R12");
    rd_chk(6'd19, 32'h0000_2FF1, "R12");
    rd_chk(6'd1, 32'd5, "R12");
    rd_chk(6'd0, 32'd1, "R12");

    // R3: disable
    set_en(1'b0);
    access(32'h0000_0000, 2'd2, 1'b1, "R3");
    rd_chk(6'd0, 32'd0, "R3");

    repeat (2) @(posedge clk);
    check(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule